// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Execute Unit

This block decodes and executes one 32-bit instruction on every clock for a small load/store RISC subset. The subset is register add, register subtract, add with a constant, word load and word store. The fetched instruction word comes in from outside. The unit drives two read indices and one write port toward an external register file, and the operands come back on two data inputs in the same cycle. It also drives a word-wide data-memory port with a byte address, write data, a write strobe and read data returning in the same cycle.

A program counter inside the unit starts at zero and steps by one word, which is four byte addresses, on every clock. Its value is the instruction fetch address. All decode, arithmetic and address forming is combinational within the cycle. The program counter is the only state.

Encodings the unit does not recognise leave both the register file and memory untouched. A load or store whose byte address is not on a word boundary raises a flag, and a store in that case is not written.

Top module: `sc_exec_unit`

## Requirements
- R1: `instrAddr` is 0 while `rstN` is low, and it grows by 4 (modulo 2^32) on every rising clock edge after reset is released.
- R2: `rfRdAddrA` always equals instruction bits [25:21] and `rfRdAddrB` always equals bits [20:16], whatever the opcode.
- R3: An instruction with bits [31:26]=0, bits [10:6]=0 and bits [5:0]=32 drives `rfWrEn`=1, `rfWrAddr`=bits [15:11] and `rfWrData`=`rfRdDataA`+`rfRdDataB`, wrapping modulo 2^32.
- R4: The same register format with bits [5:0]=34 writes `rfRdDataA`-`rfRdDataB` (modulo 2^32) to the register named by bits [15:11].
- R5: Opcode 8 in bits [31:26] drives `rfWrEn`=1, `rfWrAddr`=bits [20:16] and `rfWrData`=`rfRdDataA` plus bits [15:0] sign-extended to 32 bits.
- R6: Opcode 35 drives `memAddr`=`rfRdDataA`+sign-extended bits [15:0], `memWrEn`=0, `rfWrEn`=1, `rfWrAddr`=bits [20:16] and `rfWrData`=`memRdData`.
- R7: Opcode 43 drives `memAddr` the same way as R6 and `memWrData`=`rfRdDataB`. It sets `memWrEn`=1 when the address is aligned, and it never sets `rfWrEn`.
- R8: Any opcode other than 0, 8, 35 and 43, and opcode 0 with bits [5:0] other than 32 or 34 or with nonzero bits [10:6], drives `rfWrEn`=0 and `memWrEn`=0.
- R9: For opcodes 35 and 43, `misaligned` is 1 exactly when `memAddr`[1:0] is nonzero, and `memWrEn` is then 0. For every other instruction, `misaligned` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instrAddr | output | 32 | Fetch byte address (program counter) |
| instr | input | 32 | Instruction word for this cycle |
| rfRdAddrA | output | 5 | Register index of the base/first source |
| rfRdAddrB | output | 5 | Register index of the second source |
| rfRdDataA | input | 32 | Value of register `rfRdAddrA` |
| rfRdDataB | input | 32 | Value of register `rfRdAddrB` |
| rfWrEn | output | 1 | Register write strobe |
| rfWrAddr | output | 5 | Register write index |
| rfWrData | output | 32 | Register write value |
| memAddr | output | 32 | Data-memory byte address |
| memWrEn | output | 1 | Data-memory write strobe |
| memWrData | output | 32 | Data-memory write value |
| memRdData | input | 32 | Data-memory read value |
| misaligned | output | 1 | Word access not on a 4-byte boundary |

## Verification
Every register-file and memory output depends only on the current instruction, the operands and the read data. These outputs are therefore due in the same cycle the inputs are presented. The bench changes inputs on the falling edge and samples one nanosecond later, before the next rising edge. The fetch address is the one registered result. It is due one rising edge after the cycle it steps from, so the bench captures it on a falling edge and compares it on the falling edge after each further rising edge.

// File: rtl/sc_exec_pkg.sv
package sc_exec_pkg;

  localparam int INSTR_W = 32;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;

  typedef struct packed {
    logic regWrite;
    logic memWrite;
    logic memRead;
    logic useImm;
    logic subtract;
    logic dstIsRt;
  } ctrlStrobes_t;

endpackage

// File: rtl/sc_exec_control.sv
module sc_exec_control
  import sc_exec_pkg::*;
(
  input  logic [5:0]   opcode,
  input  logic [4:0]   shamt,
  input  logic [5:0]   funct,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (opcode)
      OPC_REG: begin
        if (shamt == 5'd0 && (funct == FN_ADD || funct == FN_SUB)) begin
          strobes.regWrite = 1'b1;
          strobes.subtract = (funct == FN_SUB);
        end
      end
      OPC_ADDI: begin
        strobes.regWrite = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.dstIsRt  = 1'b1;
      end
      OPC_LOAD: begin
        strobes.regWrite = 1'b1;
        strobes.memRead  = 1'b1;
        strobes.useImm   = 1'b1;
        strobes.dstIsRt  = 1'b1;
      end
      OPC_STORE: begin
        strobes.memWrite = 1'b1;
        strobes.useImm   = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/sc_exec_datapath.sv
module sc_exec_datapath
  import sc_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [REG_AW-1:0] rsIdx,
  input  logic [REG_AW-1:0] rtIdx,
  input  logic [REG_AW-1:0] rdIdx,
  input  logic [15:0]       imm16,
  output logic [DATA_W-1:0] pc,
  output logic [REG_AW-1:0] rfRdAddrA,
  output logic [REG_AW-1:0] rfRdAddrB,
  input  logic [DATA_W-1:0] rfRdDataA,
  input  logic [DATA_W-1:0] rfRdDataB,
  output logic              rfWrEn,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              misaligned
);

  localparam int LANE_W = $clog2(DATA_W / 8);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] aluResult;
  logic              isMemAccess;
  logic              offBoundary;

  // program counter: the only state in the unit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= pc + DATA_W'(PC_STEP);
  end

  assign rfRdAddrA = rsIdx;
  assign rfRdAddrB = rtIdx;

  assign immExt   = {{(DATA_W-16){imm16[15]}}, imm16};
  assign operandB = strobes.useImm ? immExt : rfRdDataB;

  always_comb begin
    if (strobes.subtract) aluResult = rfRdDataA - operandB;
    else                  aluResult = rfRdDataA + operandB;
  end

  assign isMemAccess = strobes.memRead | strobes.memWrite;

  generate
    if (LANE_W > 0) begin : g_laneCheck
      assign offBoundary = |aluResult[LANE_W-1:0];
    end else begin : g_noLanes
      assign offBoundary = 1'b0;
    end
  endgenerate

  assign misaligned = isMemAccess & offBoundary;

  assign memAddr   = aluResult;
  assign memWrData = rfRdDataB;
  assign memWrEn   = strobes.memWrite & ~offBoundary;

  assign rfWrEn   = strobes.regWrite;
  assign rfWrAddr = strobes.dstIsRt ? rtIdx : rdIdx;
  assign rfWrData = strobes.memRead ? memRdData : aluResult;

endmodule

// File: rtl/sc_exec_unit.sv
module sc_exec_unit
  import sc_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] instrAddr,
  input  logic [31:0]       instr,
  output logic [REG_AW-1:0] rfRdAddrA,
  output logic [REG_AW-1:0] rfRdAddrB,
  input  logic [DATA_W-1:0] rfRdDataA,
  input  logic [DATA_W-1:0] rfRdDataB,
  output logic              rfWrEn,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              misaligned
);

  ctrlStrobes_t strobes;

  sc_exec_control u_control (
    .opcode (instr[31:26]),
    .shamt  (instr[10:6]),
    .funct  (instr[5:0]),
    .strobes(strobes)
  );

  sc_exec_datapath #(
    .DATA_W (DATA_W),
    .REG_AW (REG_AW),
    .PC_STEP(PC_STEP)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rsIdx     (instr[25:21]),
    .rtIdx     (instr[20:16]),
    .rdIdx     (instr[15:11]),
    .imm16     (instr[15:0]),
    .pc        (instrAddr),
    .rfRdAddrA (rfRdAddrA),
    .rfRdAddrB (rfRdAddrB),
    .rfRdDataA (rfRdDataA),
    .rfRdDataB (rfRdDataB),
    .rfWrEn    (rfWrEn),
    .rfWrAddr  (rfWrAddr),
    .rfWrData  (rfWrData),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .misaligned(misaligned)
  );

endmodule

// File: rtl/sc_exec_unit_checker.sv
module sc_exec_unit_checker #(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [5:0]        opcode,
  input logic [DATA_W-1:0] instrAddr,
  input logic              rfWrEn,
  input logic [DATA_W-1:0] rfWrData,
  input logic [DATA_W-1:0] memRdData,
  input logic              memWrEn,
  input logic [1:0]        memAddrLow,
  input logic              misaligned
);

  logic knownOp;
  assign knownOp = (opcode == 6'd0) || (opcode == 6'd8) ||
                   (opcode == 6'd35) || (opcode == 6'd43);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> instrAddr == $past(instrAddr) + DATA_W'(PC_STEP)); // R1

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && opcode == 6'd35) |-> rfWrData == memRdData); // R6

  AST_STORE_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> opcode == 6'd43); // R7

  AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !rfWrEn); // R7

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !knownOp |-> (!rfWrEn && !memWrEn)); // R8

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> !memWrEn); // R9

  AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memAddrLow == 2'b00); // R9

  AST_FLAG_MEM_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (opcode == 6'd35 || opcode == 6'd43)); // R9

endmodule

bind sc_exec_unit sc_exec_unit_checker #(
  .DATA_W (DATA_W),
  .PC_STEP(PC_STEP)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .opcode    (instr[31:26]),
  .instrAddr (instrAddr),
  .rfWrEn    (rfWrEn),
  .rfWrData  (rfWrData),
  .memRdData (memRdData),
  .memWrEn   (memWrEn),
  .memAddrLow(memAddr[1:0]),
  .misaligned(misaligned)
);

// File: tb/sc_exec_unit_bench.sv
`timescale 1ns/1ps
module sc_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrAddr;
  logic [31:0] instr = 32'd0;
  logic [4:0]  rfRdAddrA, rfRdAddrB, rfWrAddr;
  logic [31:0] rfRdDataA = 32'd0, rfRdDataB = 32'd0;
  logic        rfWrEn, memWrEn, misaligned;
  logic [31:0] rfWrData, memAddr, memWrData;
  logic [31:0] memRdData = 32'd0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_exec_unit u_sc_exec_unit (
    .clk(clk), .rstN(rstN), .instrAddr(instrAddr), .instr(instr),
    .rfRdAddrA(rfRdAddrA), .rfRdAddrB(rfRdAddrB),
    .rfRdDataA(rfRdDataA), .rfRdDataB(rfRdDataB),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData), .misaligned(misaligned)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rWord(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iWord(input int op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] mrd);
    @(negedge clk);
    instr = w; rfRdDataA = a; rfRdDataB = b; memRdData = mrd;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset addr", instrAddr, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 held in reset", instrAddr, 32'd0);
    rstN = 1'b1;
    #1;
    chk("R1 after release before edge", instrAddr, 32'd0);
  endtask

  task automatic t_pc();
    logic [31:0] p0;
    @(negedge clk);
    p0 = instrAddr;
    @(posedge clk); @(negedge clk);
    chk("R1 step", instrAddr, p0 + 32'd4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 four steps", instrAddr, p0 + 32'd16);
  endtask

  task automatic t_add();
    apply(rWord(5, 6, 7, 0, 32), 32'h10, 32'h22, 32'h0);
    chk("R2 read A", 32'(rfRdAddrA), 32'd5);
    chk("R2 read B", 32'(rfRdAddrB), 32'd6);
    chk("R3 wen", 32'(rfWrEn), 32'd1);
    chk("R3 waddr", 32'(rfWrAddr), 32'd7);
    chk("R3 sum", rfWrData, 32'h32);
    chk("R3 no mem write", 32'(memWrEn), 32'd0);
    chk("R9 no flag on add", 32'(misaligned), 32'd0);
    apply(rWord(1, 2, 31, 0, 32), 32'hFFFF_FFFF, 32'h2, 32'h0);
    chk("R3 wrap", rfWrData, 32'h1);
    apply(rWord(1, 2, 3, 0, 32), 32'h1, 32'h2, 32'h0);
    chk("R9 odd sum no flag", 32'(misaligned), 32'd0);
  endtask

  task automatic t_sub();
    apply(rWord(9, 10, 11, 0, 34), 32'd5, 32'd7, 32'h0);
    chk("R4 wen", 32'(rfWrEn), 32'd1);
    chk("R4 waddr", 32'(rfWrAddr), 32'd11);
    chk("R4 diff wrap", rfWrData, 32'hFFFF_FFFE);
    apply(rWord(9, 10, 12, 0, 34), 32'h8000_0000, 32'h1, 32'h0);
    chk("R4 diff", rfWrData, 32'h7FFF_FFFF);
  endtask

  task automatic t_addi();
    apply(iWord(8, 17, 18, 16'hFFF6), 32'd100, 32'hDEAD, 32'h0);
    chk("R5 wen", 32'(rfWrEn), 32'd1);
    chk("R5 waddr rt", 32'(rfWrAddr), 32'd18);
    chk("R5 negative imm", rfWrData, 32'd90);
    apply(iWord(8, 0, 1, 16'h7FFF), 32'd0, 32'h0, 32'h0);
    chk("R5 max positive imm", rfWrData, 32'h0000_7FFF);
    apply(iWord(8, 0, 1, 16'h8000), 32'd0, 32'h0, 32'h0);
    chk("R5 most negative imm", rfWrData, 32'hFFFF_8000);
  endtask

  task automatic t_load();
    apply(iWord(35, 4, 8, 16'hFFFC), 32'h1000, 32'h5555, 32'hDEAD_BEEF);
    chk("R6 addr", memAddr, 32'h0FFC);
    chk("R6 wen", 32'(rfWrEn), 32'd1);
    chk("R6 waddr rt", 32'(rfWrAddr), 32'd8);
    chk("R6 data from mem", rfWrData, 32'hDEAD_BEEF);
    chk("R6 no mem write", 32'(memWrEn), 32'd0);
    chk("R9 aligned load", 32'(misaligned), 32'd0);
    apply(iWord(35, 4, 8, 16'h0002), 32'h1000, 32'h0, 32'h0);
    chk("R9 misaligned load", 32'(misaligned), 32'd1);
  endtask

  task automatic t_store();
    apply(iWord(43, 18, 8, 16'd24), 32'h200, 32'h1234_5678, 32'h0);
    chk("R7 addr", memAddr, 32'h218);
    chk("R7 wdata", memWrData, 32'h1234_5678);
    chk("R7 mem wen", 32'(memWrEn), 32'd1);
    chk("R7 no reg write", 32'(rfWrEn), 32'd0);
    chk("R9 aligned store", 32'(misaligned), 32'd0);
    apply(iWord(43, 18, 8, 16'd0), 32'h201, 32'h1, 32'h0);
    chk("R9 misaligned flag", 32'(misaligned), 32'd1);
    chk("R9 write suppressed", 32'(memWrEn), 32'd0);
    apply(iWord(43, 18, 8, 16'hFFFF), 32'h204, 32'h1, 32'h0);
    chk("R9 negative offset misaligned", 32'(misaligned), 32'd1);
  endtask

  task automatic t_nop();
    apply(rWord(1, 2, 3, 0, 33), 32'h1, 32'h2, 32'h0);
    chk("R8 funct 33 reg", 32'(rfWrEn), 32'd0);
    chk("R8 funct 33 mem", 32'(memWrEn), 32'd0);
    apply(rWord(1, 2, 3, 4, 32), 32'h1, 32'h2, 32'h0);
    chk("R8 nonzero shamt", 32'(rfWrEn), 32'd0);
    apply(iWord(2, 1, 2, 16'h0), 32'h0, 32'h0, 32'h0);
    chk("R8 op 2 reg", 32'(rfWrEn), 32'd0);
    chk("R8 op 2 mem", 32'(memWrEn), 32'd0);
    apply(iWord(41, 1, 2, 16'h1), 32'h0, 32'h0, 32'h0);
    chk("R8 op 41 mem", 32'(memWrEn), 32'd0);
    chk("R9 op 41 no flag", 32'(misaligned), 32'd0);
  endtask

  initial begin
    t_reset();
    t_pc();
    t_add();
    t_sub();
    t_addi();
    t_load();
    t_store();
    t_nop();
    t_pc();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule